// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Host

This block is the host side of a single-wire, open-drain serial link. The line idles high through an external pull-up. Either end signals by pulling it low, so the block has only an output-enable that drives the line low. Each bit occupies a fixed cycle time. The cycle opens with a falling edge, and the length of the low pulse carries the value: a short pulse is a 1 and a long pulse is a 0. The line is then released high for the rest of the cycle.

A transaction starts with a one-cycle `start_i`. The block first sends a command byte that holds a write/read flag and a 7-bit register address. On a write it then sends the data byte. On a read it releases the line and times the slave's pulses to recover a byte. Before the first transaction after reset, after any response timeout, or on request, the block precedes the command with a break. A break is a long low period followed by a high recovery period, and it puts the slave back into a known state. If the slave does not start a bit within the response window, the block raises an error flag and returns to idle without new read data. All durations are parameters counted in clock cycles. At the default values the bit rate is 5 kbit/s with a 250 MHz clock.

Top module: `rto_link_host`

## Requirements
- R1: After reset, `line_oe_o`, `busy_o`, `done_o` and `err_o` are 0 and `rdata_o` is 0. `line_oe_o` is only asserted while `busy_o` is 1.
- R2: The first accepted transaction after reset is preceded by a break: `line_oe_o` high for exactly BRK_LOW cycles, then low for exactly BRK_REC cycles, before the first command bit.
- R3: The command byte is {`wr_i`, `addr_i`[6:0]}, so bit 7 is 1 for a write and 0 for a read. It is sent least-significant bit first.
- R4: A 1 is sent as ONE_LOW cycles of `line_oe_o` high and a 0 as ZERO_LOW cycles. Consecutive bits start exactly BIT_CYC cycles apart.
- R5: On a write, the 8 data bits follow the command, least-significant bit first. When the last bit cycle ends, `done_o` pulses for one cycle and `busy_o` drops in the same cycle.
- R6: On a read, the block keeps `line_oe_o` low and samples the synchronised line SAMPLE_PT cycles after each detected falling edge, with a high level giving a 1. The 8 bits are assembled least-significant first into `rdata_o`, which is updated together with a `done_o` pulse.
- R7: If no falling edge arrives within RESP_TIMEOUT cycles of waiting for a slave bit, `err_o` is set and the block returns to idle. `done_o` does not pulse and `rdata_o` keeps its previous value. `err_o` stays high until the next accepted start.
- R8: The transaction accepted after a timeout is preceded by a break.
- R9: `brk_i` high together with an accepted `start_i` forces a break before the command, even when none is pending.
- R10: With no break pending and `brk_i` low, the first command bit starts directly, with no break.
- R11: `start_i` while `busy_o` is 1 is ignored. The ongoing transaction's pulse sequence and its single `done_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transaction (accepted when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| brk_i | input | 1 | Force a break before this transaction |
| addr_i | input | 7 | Slave register address |
| wdata_i | input | 8 | Data byte for a write |
| line_i | input | 1 | Sensed level of the shared line (asynchronous) |
| line_oe_o | output | 1 | 1 = pull the line low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at successful completion |
| err_o | output | 1 | Response timeout flag |
| rdata_o | output | 8 | Last byte read from the slave |

## Verification
The embedded properties check on every cycle the following rules: the line is never pulled outside a transaction or while the slave owns it, completion is a single-cycle pulse, the read register changes only on completion, and a timeout lands the block idle with the error flag set. They also check that the pulse timer is never restarted mid-bit and that the receive sampler is only re-armed when free. Pulse widths, bit spacing, break and recovery lengths, least-significant-first order, the decision on when a break is due, and the sampling of slave pulse widths are judged only by the bench. It records every low pulse the host drives and plays a slave that answers reads or stays silent.

// File: rtl/rto_pkg.sv
// Shared types for the single-wire return-to-one host.
package rto_pkg;

    // Transaction sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK,
        ST_CMD,
        ST_WDAT,
        ST_RDAT
    } rto_state_e;

    // Receive sampler modes.
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_SAMP
    } rx_mode_e;

endpackage

// File: rtl/rto_sync.sv
// Two-flop synchroniser for the sensed line, plus a falling-edge detector.
// Assumes line_i is asynchronous and idles high. Outputs are registered-level
// based; fall_o is high for one cycle per detected high-to-low transition.
module rto_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    // Shift the line through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign level_o = s2_q;
    assign fall_o  = s3_q & ~s2_q;

endmodule

// File: rtl/rto_bit_tx.sv
// Low-pulse generator: on go_i, drives oe_o for low_len_i cycles and then
// releases it until cyc_len_i cycles have elapsed. done_o marks the final
// cycle, in which a new go_i may be accepted so frames run back to back.
// Assumes 0 < low_len_i < cyc_len_i. Used for both data bits and breaks.
module rto_bit_tx #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [CW-1:0] low_len_i,
    input  logic [CW-1:0] cyc_len_i,
    output logic          oe_o,
    output logic          done_o
);
    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lo_q;
    logic [CW-1:0] cy_q;

    assign done_o = active_q && (cnt_q == cy_q - 1'b1);
    assign oe_o   = active_q && (cnt_q < lo_q);

    // Latch the frame lengths on go and count through the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            lo_q     <= '0;
            cy_q     <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            lo_q     <= low_len_i;
            cy_q     <= cyc_len_i;
        end else if (done_o) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A new frame may only start when the previous one is over.
    p_go_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (!active_q || done_o));

endmodule

// File: rtl/rto_bit_rx.sv
// Slave-bit sampler: after arm_i, waits for a falling edge; SAMPLE cycles
// after it, reports the synchronised level as one bit. If no edge arrives
// within TIMEOUT cycles it reports tmo_o instead. Returns to idle after
// either event; arm_i takes priority so it can be re-armed on valid_o.
module rto_bit_rx
    import rto_pkg::*;
#(
    parameter int SAMPLE  = 17,
    parameter int TIMEOUT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic fall_i,
    input  logic level_i,
    output logic valid_o,
    output logic bit_o,
    output logic tmo_o
);
    localparam int TMAX = (TIMEOUT > SAMPLE) ? TIMEOUT : SAMPLE;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SAMP_LAST = TW'(SAMPLE - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TIMEOUT - 1);

    rx_mode_e      mode_q;
    logic [TW-1:0] cnt_q;

    assign valid_o = (mode_q == RX_SAMP) && (cnt_q == SAMP_LAST);
    assign bit_o   = level_i;
    assign tmo_o   = (mode_q == RX_WAIT) && !fall_i && (cnt_q == TMO_LAST);

    // Walk wait -> sample -> idle, or wait -> idle on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RX_IDLE;
            cnt_q  <= '0;
        end else if (arm_i) begin
            mode_q <= RX_WAIT;
            cnt_q  <= '0;
        end else begin
            unique case (mode_q)
                RX_WAIT: begin
                    if (fall_i) begin
                        mode_q <= RX_SAMP;
                        cnt_q  <= '0;
                    end else if (tmo_o) begin
                        mode_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_SAMP: begin
                    if (valid_o) mode_q <= RX_IDLE;
                    else         cnt_q  <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // The sequencer only arms a free sampler (or one just finishing a bit).
    p_arm_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |-> (mode_q == RX_IDLE || valid_o));

endmodule

// File: rtl/rto_link_host.sv
// Host controller for a single-wire, open-drain, return-to-one serial link.
// Sequences an optional break, the command byte, then a write data byte or
// a received byte. Assumes an external pull-up; line_oe_o = 1 pulls low.
// All timings are in clock cycles with ONE_LOW < SAMPLE_PT < ZERO_LOW < BIT_CYC.
module rto_link_host
    import rto_pkg::*;
#(
    parameter int BIT_CYC      = 50000,
    parameter int ONE_LOW      = 10000,
    parameter int ZERO_LOW     = 33000,
    parameter int SAMPLE_PT    = 21000,
    parameter int BRK_LOW      = 47500,
    parameter int BRK_REC      = 10000,
    parameter int RESP_TIMEOUT = 62500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wr_i,
    input  logic       brk_i,
    input  logic [6:0] addr_i,
    input  logic [7:0] wdata_i,
    input  logic       line_i,
    output logic       line_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [7:0] rdata_o
);
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(BYTE_W);
    localparam int BRK_CYC = BRK_LOW + BRK_REC;
    localparam int MAXC    = (BRK_CYC > BIT_CYC) ? BRK_CYC : BIT_CYC;
    localparam int CW      = $clog2(MAXC + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    rto_state_e        state_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] wd_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q;
    logic              need_brk_q;
    logic              done_q;
    logic              err_q;
    logic [BYTE_W-1:0] rdata_q;

    logic              tx_go, tx_done;
    logic [CW-1:0]     tx_low, tx_cyc;
    logic              rx_arm, rx_valid, rx_bit, rx_tmo;
    logic              ln_level, ln_fall;
    logic [BYTE_W-1:0] cmd_byte;

    assign cmd_byte = {wr_i, addr_i};

    // Low-pulse length that encodes one bit value.
    function automatic logic [CW-1:0] low_for(input logic b);
        return b ? CW'(ONE_LOW) : CW'(ZERO_LOW);
    endfunction

    rto_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .level_o (ln_level),
        .fall_o  (ln_fall)
    );

    rto_bit_tx #(.CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (tx_go),
        .low_len_i (tx_low),
        .cyc_len_i (tx_cyc),
        .oe_o      (line_oe_o),
        .done_o    (tx_done)
    );

    rto_bit_rx #(.SAMPLE(SAMPLE_PT), .TIMEOUT(RESP_TIMEOUT)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (rx_arm),
        .fall_i  (ln_fall),
        .level_i (ln_level),
        .valid_o (rx_valid),
        .bit_o   (rx_bit),
        .tmo_o   (rx_tmo)
    );

    // Decide when to launch the next pulse frame or arm the sampler.
    always_comb begin
        tx_go  = 1'b0;
        tx_low = low_for(sh_q[0]);
        tx_cyc = CW'(BIT_CYC);
        rx_arm = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                tx_go = 1'b1;
                if (need_brk_q || brk_i) begin
                    tx_low = CW'(BRK_LOW);
                    tx_cyc = CW'(BRK_CYC);
                end else begin
                    tx_low = low_for(cmd_byte[0]);
                end
            end
            ST_BRK: if (tx_done) begin
                tx_go  = 1'b1;
                tx_low = low_for(sh_q[0]);
            end
            ST_CMD: if (tx_done) begin
                if (idx_q == IDX_LAST) begin
                    if (wr_q) begin
                        tx_go  = 1'b1;
                        tx_low = low_for(wd_q[0]);
                    end else begin
                        rx_arm = 1'b1;
                    end
                end else begin
                    tx_go  = 1'b1;
                    tx_low = low_for(sh_q[1]);
                end
            end
            ST_WDAT: if (tx_done && idx_q != IDX_LAST) begin
                tx_go  = 1'b1;
                tx_low = low_for(sh_q[1]);
            end
            ST_RDAT: if (rx_valid && idx_q != IDX_LAST) rx_arm = 1'b1;
            default: ;
        endcase
    end

    // Advance the transaction, shift bits, and record results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sh_q       <= '0;
            wd_q       <= '0;
            idx_q      <= '0;
            wr_q       <= 1'b0;
            need_brk_q <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= (need_brk_q || brk_i) ? ST_BRK : ST_CMD;
                    sh_q    <= cmd_byte;
                    wd_q    <= wdata_i;
                    wr_q    <= wr_i;
                    idx_q   <= '0;
                    err_q   <= 1'b0;
                end
                ST_BRK: if (tx_done) begin
                    state_q    <= ST_CMD;
                    need_brk_q <= 1'b0;
                end
                ST_CMD: if (tx_done) begin
                    idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        state_q <= wr_q ? ST_WDAT : ST_RDAT;
                        sh_q    <= wd_q;
                    end else begin
                        sh_q <= sh_q >> 1;
                    end
                end
                ST_WDAT: if (tx_done) begin
                    if (idx_q == IDX_LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RDAT: begin
                    if (rx_valid) begin
                        sh_q <= {rx_bit, sh_q[BYTE_W-1:1]};
                        if (idx_q == IDX_LAST) begin
                            rdata_q <= {rx_bit, sh_q[BYTE_W-1:1]};
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else if (rx_tmo) begin
                        err_q      <= 1'b1;
                        need_brk_q <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign rdata_o = rdata_q;

    p_oe_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_o |-> busy_o);
    p_release_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDAT) |-> !line_oe_o);
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_start_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    p_tmo_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo |=> (err_o && !busy_o && !done_o));
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));

endmodule

// File: tb/rto_link_host_tb.sv
// Directed bench: records every host low pulse and models the slave.
module rto_link_host_tb_top;
    localparam int BIT_CYC = 40, ONE_LOW = 8, ZERO_LOW = 26, SAMPLE_PT = 17;
    localparam int BRK_LOW = 60, BRK_REC = 20, RESP_TIMEOUT = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, wr_i = 1'b0, brk_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic slave_oe = 1'b0;
    logic line_i;
    logic line_oe_o, busy_o, done_o, err_o;
    logic [7:0] rdata_o;

    int n_chk = 0, n_fail = 0;
    int pl [0:511];
    int hl [0:511];
    int np = 0, lo_run = 0, hi_run = 0, cur_hi = 0, done_cnt = 0, cycles = 0;

    always #2 clk = ~clk;
    assign line_i = !(line_oe_o || slave_oe);

    rto_link_host #(
        .BIT_CYC(BIT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
        .SAMPLE_PT(SAMPLE_PT), .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC),
        .RESP_TIMEOUT(RESP_TIMEOUT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .brk_i(brk_i), .addr_i(addr_i), .wdata_i(wdata_i), .line_i(line_i),
        .line_oe_o(line_oe_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .rdata_o(rdata_o)
    );

    // Record low-pulse and preceding high-gap lengths of the host drive.
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            lo_run = 0; hi_run = 0;
        end else begin
            if (done_o) done_cnt++;
            if (line_oe_o) begin
                if (lo_run == 0) cur_hi = hi_run;
                lo_run++; hi_run = 0;
            end else begin
                if (lo_run > 0 && np < 512) begin
                    pl[np] = lo_run; hl[np] = cur_hi; np++;
                end
                lo_run = 0; hi_run++;
            end
        end
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic kick(input bit wr, input bit brk, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; brk_i = brk; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0; brk_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Check the pulse train from index base: optional break, then nbits bits.
    task automatic check_train(input int base, input bit exp_brk, input int nbits,
                               input logic [15:0] bits, input string req);
        int k;
        k = base;
        chk(np - base == nbits + int'(exp_brk), "R11 pulse count", np - base, nbits + int'(exp_brk));
        if (exp_brk) begin
            chk(pl[k] == BRK_LOW, "R2 break low", pl[k], BRK_LOW);
            chk(hl[k+1] == BRK_REC, "R2 break recovery", hl[k+1], BRK_REC);
            k++;
        end else begin
            chk(pl[k] != BRK_LOW, "R10 no break", pl[k], ONE_LOW);
        end
        for (int i = 0; i < nbits; i++) begin
            chk(pl[k+i] == (bits[i] ? ONE_LOW : ZERO_LOW), {req, " R3 R4 bit width"},
                pl[k+i], bits[i] ? ONE_LOW : ZERO_LOW);
            if (i > 0)
                chk(pl[k+i-1] + hl[k+i] == BIT_CYC, "R4 bit cycle",
                    pl[k+i-1] + hl[k+i], BIT_CYC);
        end
    endtask

    task automatic slave_send(input int base, input int ncmd, input logic [7:0] b);
        for (int i = 0; i < 5000 && np < base + ncmd; i++) @(negedge clk);
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            slave_oe = 1'b1;
            repeat (b[i] ? ONE_LOW : ZERO_LOW) @(negedge clk);
            slave_oe = 1'b0;
            repeat (BIT_CYC - (b[i] ? ONE_LOW : ZERO_LOW)) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(line_oe_o == 0 && busy_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags",
            {line_oe_o, busy_o, done_o, err_o}, 0);
        chk(rdata_o == 8'h00, "R1 reset rdata", rdata_o, 0);
    endtask

    task automatic t_write(input bit brk, input bit exp_brk, input logic [6:0] a,
                           input logic [7:0] d, input bit poke_busy, input string req);
        int base, dc;
        base = np; dc = done_cnt;
        kick(1'b1, brk, a, d);
        if (poke_busy) begin
            repeat (50) @(negedge clk);
            kick(1'b0, 1'b1, 7'h00, 8'h00);
        end
        wait_idle();
        check_train(base, exp_brk, 16, {d, 1'b1, a}, req);
        chk(done_cnt - dc == 1, {req, " R5 one done"}, done_cnt - dc, 1);
        chk(busy_o == 0 && err_o == 0, {req, " R5 idle after write"}, {busy_o, err_o}, 0);
    endtask

    task automatic t_read(input bit exp_brk, input logic [6:0] a, input logic [7:0] b);
        int base, dc;
        base = np; dc = done_cnt;
        kick(1'b0, 1'b0, a, 8'h00);
        slave_send(base, 8 + int'(exp_brk), b);
        wait_idle();
        check_train(base, exp_brk, 8, {8'h00, 1'b0, a}, "R6 read cmd");
        chk(rdata_o == b, "R6 read data", rdata_o, b);
        chk(done_cnt - dc == 1 && err_o == 0, "R6 read done", done_cnt - dc, 1);
    endtask

    task automatic t_timeout(input logic [6:0] a);
        int base, dc;
        logic [7:0] prev;
        base = np; dc = done_cnt; prev = rdata_o;
        kick(1'b0, 1'b0, a, 8'h00);
        wait_idle();
        chk(err_o == 1, "R7 error flag", err_o, 1);
        chk(busy_o == 0, "R7 back to idle", busy_o, 0);
        chk(done_cnt == dc, "R7 no done", done_cnt - dc, 0);
        chk(rdata_o == prev, "R7 rdata kept", rdata_o, prev);
        chk(np - base == 8, "R7 only command sent", np - base, 8);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(1'b0, 1'b1, 7'h15, 8'hA6, 1'b0, "R2 first write");
        t_write(1'b0, 1'b0, 7'h7F, 8'h01, 1'b1, "R10 R11 write");
        t_read(1'b0, 7'h22, 8'h5C);
        t_read(1'b0, 7'h01, 8'h81);
        t_timeout(7'h33);
        t_write(1'b0, 1'b1, 7'h40, 8'hF0, 1'b0, "R8 after timeout");
        chk(err_o == 0, "R7 error cleared on start", err_o, 0);
        t_write(1'b1, 1'b1, 7'h0A, 8'h3C, 1'b0, "R9 forced break");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule